// File: doc/BRIEF.md
# Multi-Event Clock-Domain Crossing

This block moves a vector of single-cycle event pulses from a source clock domain into an unrelated destination clock domain. All event bits share one request/acknowledge toggle handshake. When the source side is idle and an event is waiting, it copies the pending bits into a hold register and flips its request toggle. The toggle passes through a multi-stage synchronizer. When the destination side sees the toggle change, it captures the hold register straight into its output register for one cycle and flips its acknowledge toggle. That toggle returns through a second synchronizer and frees the source for the next transfer.

Events can arrive while a transfer is still in flight. These are OR-merged into a pending register and sent together in the next transfer, so no bit is lost. Several pulses of the same bit that arrive before their transfer starts reach the destination as a single pulse. A typical use is to report sticky error and status events from a fast data-path clock to a slower control clock.

Top module: `evx_event_cdc`

## Requirements
- R1: While either reset is active, and after reset with no event input, the destination output vector is all zero. Events presented during reset are discarded.
- R2: Each non-zero destination output vector lasts exactly one destination clock cycle. Two consecutive destination cycles never both carry a non-zero vector.
- R3: Every event bit pulsed at the source appears at the destination output at least once, once the input has been quiet for a full handshake round trip. This holds for events that arrive during an in-flight transfer and for events that arrive in the same cycle a transfer starts.
- R4: An output bit is set only if that same bit was pulsed at the source since it last appeared at the output.
- R5: Repeated pulses of one bit that occur before their transfer starts are merged. For each bit, the number of output pulses never exceeds the number of input pulses.
- R6: A transfer starts, meaning the request toggle flips, only when the synchronized acknowledge equals the request toggle. It always carries a non-zero event vector.
- R7: The hold register does not change while a transfer is in flight, that is, while the request toggle differs from the synchronized acknowledge.
- R8: With nothing pending and no event input, the request toggle does not flip and the output stays zero.
- R9: R2 to R5 hold both when the destination clock is slower than the source clock and when it is faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_ev_i | input | N_EVENTS | Single-cycle event pulses, one bit per event, in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_ev_o | output | N_EVENTS | Delivered event vector, asserted for one destination cycle per transfer |

## Verification
Two source-side functions can fall in the same source cycle: starting a new transfer, and accepting a fresh event into the pending register. A third can join them: the acknowledge returning. Back-to-back bursts of every pattern of a four-bit event vector provoke this overlap, with pulses on every source cycle and with gaps of several cycles. Each burst runs once with the destination clock slower than the source clock and once with it faster. After each burst the bench waits for the input to go quiet. It then compares, bit by bit, the counts of input and output pulses: a bit that was pulsed must have been delivered, a bit that was not pulsed must not appear, and no bit may be delivered more often than it was pulsed.

// File: rtl/evx_pkg.sv
package evx_pkg;

    localparam int EVX_DEF_EVENTS = 2;
    localparam int EVX_MIN_STAGES = 2;

    typedef enum logic {
        EVX_IDLE = 1'b0,
        EVX_BUSY = 1'b1
    } evx_phase_e;

endpackage

// File: rtl/evx_sync.sv
module evx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[LAST];

endmodule

// File: rtl/evx_src_side.sv
module evx_src_side
    import evx_pkg::*;
#(
    parameter int N_EVENTS = EVX_DEF_EVENTS,
    parameter int STAGES   = EVX_MIN_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_EVENTS-1:0] ev_i,
    input  logic                ack_tgl_i,
    output logic                req_o,
    output logic                ack_sync_o,
    output logic [N_EVENTS-1:0] pend_o,
    output logic [N_EVENTS-1:0] hold_o
);
    typedef struct packed {
        logic                req;
        logic [N_EVENTS-1:0] pend;
        logic [N_EVENTS-1:0] hold;
    } src_state_t;

    src_state_t          st_d;
    src_state_t          st_q;
    logic                ack_sync;
    logic [N_EVENTS-1:0] merged;
    evx_phase_e          phase;

    evx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_i),
        .q     (ack_sync)
    );

    always_comb begin
        st_d   = st_q;
        merged = st_q.pend | ev_i;
        phase  = (ack_sync == st_q.req) ? EVX_IDLE : EVX_BUSY;
        if (phase == EVX_IDLE && |merged) begin
            st_d.req  = ~st_q.req;
            st_d.hold = merged;
            st_d.pend = '0;
        end else begin
            st_d.pend = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o      = st_q.req;
    assign ack_sync_o = ack_sync;
    assign pend_o     = st_q.pend;
    assign hold_o     = st_q.hold;

endmodule

// File: rtl/evx_dst_side.sv
module evx_dst_side
    import evx_pkg::*;
#(
    parameter int N_EVENTS = EVX_DEF_EVENTS,
    parameter int STAGES   = EVX_MIN_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_tgl_i,
    input  logic [N_EVENTS-1:0] hold_i,
    output logic                ack_o,
    output logic                req_sync_o,
    output logic [N_EVENTS-1:0] ev_o
);
    typedef struct packed {
        logic                ack;
        logic [N_EVENTS-1:0] ev;
    } dst_state_t;

    dst_state_t st_d;
    dst_state_t st_q;
    logic       req_sync;

    evx_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl_i),
        .q     (req_sync)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = '0;
        if (req_sync != st_q.ack) begin
            // hold_i is stable for the whole flight of the toggle
            st_d.ev  = hold_i;
            st_d.ack = req_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o      = st_q.ack;
    assign req_sync_o = req_sync;
    assign ev_o       = st_q.ev;

endmodule

// File: rtl/evx_event_cdc.sv
module evx_event_cdc
    import evx_pkg::*;
#(
    parameter int N_EVENTS = EVX_DEF_EVENTS,
    parameter int STAGES   = EVX_MIN_STAGES
) (
    input  logic                src_clk,
    input  logic                src_rst_n,
    input  logic [N_EVENTS-1:0] src_ev_i,
    input  logic                dst_clk,
    input  logic                dst_rst_n,
    output logic [N_EVENTS-1:0] dst_ev_o
);
    logic                src_req;
    logic                src_ack_sync;
    logic [N_EVENTS-1:0] src_pend;
    logic [N_EVENTS-1:0] src_hold;
    logic                dst_ack;
    logic                dst_req_sync;

    evx_src_side #(.N_EVENTS(N_EVENTS), .STAGES(STAGES)) u_src (
        .clk        (src_clk),
        .rst_n      (src_rst_n),
        .ev_i       (src_ev_i),
        .ack_tgl_i  (dst_ack),
        .req_o      (src_req),
        .ack_sync_o (src_ack_sync),
        .pend_o     (src_pend),
        .hold_o     (src_hold)
    );

    evx_dst_side #(.N_EVENTS(N_EVENTS), .STAGES(STAGES)) u_dst (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .req_tgl_i  (src_req),
        .hold_i     (src_hold),
        .ack_o      (dst_ack),
        .req_sync_o (dst_req_sync),
        .ev_o       (dst_ev_o)
    );

endmodule

// File: rtl/evx_event_cdc_chk.sv
module evx_event_cdc_chk #(
    parameter int N_EVENTS = 2
) (
    input logic                src_clk,
    input logic                src_rst_n,
    input logic                dst_clk,
    input logic                dst_rst_n,
    input logic                src_req,
    input logic                src_ack_sync,
    input logic [N_EVENTS-1:0] src_pend,
    input logic [N_EVENTS-1:0] src_hold,
    input logic [N_EVENTS-1:0] src_ev_i,
    input logic                dst_req_sync,
    input logic                dst_ack,
    input logic [N_EVENTS-1:0] dst_ev_o
);

    assert_launch_only_idle_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req != $past(src_req)) |-> ($past(src_req) == $past(src_ack_sync)));

    assert_launch_nonempty_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req != $past(src_req)) |-> (src_hold != '0));

    assert_hold_stable_R7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        ((src_req != src_ack_sync) && $past(src_req != src_ack_sync)) |-> $stable(src_hold));

    assert_no_idle_launch_R8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        ((src_req == src_ack_sync) && (src_pend == '0) && (src_ev_i == '0)) |=> $stable(src_req));

    assert_keep_in_flight_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req != src_ack_sync) |=> ((src_pend & $past(src_pend | src_ev_i)) == $past(src_pend | src_ev_i)));

    assert_single_pulse_R2: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_ev_o != '0) |=> (dst_ev_o == '0));

    assert_out_from_req_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_ev_o != '0) |-> ($past(dst_req_sync) != $past(dst_ack)));

    assert_ack_follows_R3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_req_sync != dst_ack) |=> (dst_ack == $past(dst_req_sync)));

endmodule

bind evx_event_cdc evx_event_cdc_chk #(.N_EVENTS(N_EVENTS)) u_evx_chk (
    .src_clk      (src_clk),
    .src_rst_n    (src_rst_n),
    .dst_clk      (dst_clk),
    .dst_rst_n    (dst_rst_n),
    .src_req      (src_req),
    .src_ack_sync (src_ack_sync),
    .src_pend     (src_pend),
    .src_hold     (src_hold),
    .src_ev_i     (src_ev_i),
    .dst_req_sync (dst_req_sync),
    .dst_ack      (dst_ack),
    .dst_ev_o     (dst_ev_o)
);

// File: tb/tb_evx_event_cdc.sv
`timescale 1ns/1ps
module tb_evx_event_cdc;
    localparam int NB = 4;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    logic          src_rst_n = 1'b0;
    logic          dst_rst_n = 1'b0;
    logic [NB-1:0] src_ev = '0;
    logic [NB-1:0] dst_ev;
    real           dst_half = 13.0;

    int checks = 0;
    int failures = 0;
    int pulse_fail = 0;
    int out_tot [NB];
    int in_tot  [NB];
    logic [NB-1:0] prev_out = '0;
    bit done = 0;

    evx_event_cdc #(.N_EVENTS(NB), .STAGES(2)) dut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_ev_i  (src_ev),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_ev_o  (dst_ev)
    );

    always #4 src_clk = ~src_clk;            // 125 MHz source clock
    always begin
        #(dst_half) dst_clk = ~dst_clk;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            out_tot[b] = 0;
            in_tot[b]  = 0;
        end
    end

    // output monitor: pulse width (R2) and per-bit delivery counts
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_ev != '0 && prev_out != '0) pulse_fail++;
            for (int b = 0; b < NB; b++) out_tot[b] += int'(dst_ev[b]);
            prev_out = dst_ev;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_round(input logic [NB-1:0] pat, input int burst, input int stride);
        int base_in  [NB];
        int base_out [NB];
        int din;
        int dout;
        for (int b = 0; b < NB; b++) begin
            base_in[b]  = in_tot[b];
            base_out[b] = out_tot[b];
        end
        for (int k = 0; k < burst; k++) begin
            @(negedge src_clk);
            src_ev = pat;
            for (int b = 0; b < NB; b++) in_tot[b] += int'(pat[b]);
            for (int s = 1; s < stride; s++) begin
                @(negedge src_clk);
                src_ev = '0;
            end
        end
        @(negedge src_clk);
        src_ev = '0;
        repeat (40) @(negedge dst_clk);
        repeat (40) @(negedge src_clk);
        for (int b = 0; b < NB; b++) begin
            din  = in_tot[b]  - base_in[b];
            dout = out_tot[b] - base_out[b];
            if (pat == '0)
                check(dout == 0, "R8 quiet input gives no output", dout, 0);
            else if (din > 0)
                check(dout > 0, "R3 pulsed bit delivered", dout, 1);
            else
                check(dout == 0, "R4 unpulsed bit absent", dout, 0);
            check(dout <= din, "R5 output count within input count", dout, din);
        end
    endtask

    initial begin
        // R1: events during reset are discarded, output held at zero
        src_ev = '1;
        repeat (5) @(negedge src_clk);
        check(dst_ev == '0, "R1 output zero in reset", int'(dst_ev), 0);
        src_ev = '0;
        @(negedge src_clk);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        repeat (40) @(negedge dst_clk);
        check(out_tot[0] + out_tot[1] + out_tot[2] + out_tot[3] == 0,
              "R1 nothing delivered after reset", out_tot[0] + out_tot[1] + out_tot[2] + out_tot[3], 0);

        // R9: both clock ratios; R6/R7 exercised by back-to-back bursts
        for (int ratio = 0; ratio < 2; ratio++) begin
            dst_half = (ratio == 0) ? 13.0 : 2.9;
            repeat (4) @(negedge dst_clk);
            for (int p = 0; p < (1 << NB); p++) begin
                run_round(NB'(p), 1, 1);
                run_round(NB'(p), 5, 1);
                run_round(NB'(p), 3, 3);
            end
        end

        check(pulse_fail == 0, "R2 single-cycle pulses", pulse_fail, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule